// File: doc/BRIEF.md
# Dual-Source Gated Timer with Overflow-Driven PWM

This block is a 16-bit up-counter whose count advances only on a rising edge of the AND of two source levels. Each of the two sources is chosen by its own 3-bit code. A code can pick one of several prescaled rate levels, a constant high, an external pin or nothing. Because the two are combined by AND, either source can gate the other. A separate prescaler supplies the rate levels on `rate_lvl` as square waves in the block's clock domain. The two external pins cross clock domains and are synchronized inside the block.

When the count wraps past its all-ones value, the block does four things. It reloads the count from a reload register that software sets. It flips a toggle output. It advances a 4-bit phase counter. It raises a sticky interrupt flag if the interrupt is enabled. The PWM output is high while the phase is below a 4-bit width field, which gives a pulse of 0 to 15 overflows in every 16.

Software reaches four registers through a simple write port and a combinational read port.

Top module: `dual_src_timer`

## Requirements
- R1: A tick happens in the cycle after the AND of the selected A and B levels goes from 0 to 1. A level that stays high gives exactly one tick. A rising edge on one source while the other is low gives no tick. Setting both sources to constant high by a control write gives a single tick.
- R2: Source A code is control bits [2:0]. The codes are: 0, 1 and 6 off; 2 `rate_lvl[0]`; 3 `rate_lvl[1]`; 4 `rate_lvl[2]`; 5 constant high; 7 synchronized `ext_a`.
- R3: Source B code is control bits [5:3]. The codes are: 0 `rate_lvl[3]`; 1 `rate_lvl[4]`; 2 `rate_lvl[5]`; 3 `tb1_lvl`; 4 `rate_lvl[6]`; 5 `rate_lvl[7]`; 6 constant high; 7 synchronized `ext_b`.
- R4: Each tick adds one to the count while the count is below all-ones. Without a tick the count holds.
- R5: A tick at all-ones is an overflow, and the count is loaded with the reload value.
- R6: A write to address 0 sets only the reload value and leaves the running count unchanged. A read of address 0 returns the count, zero-extended. Addresses 1, 2 and 3 read back the control register, the interrupt enable and the flag.
- R7: Each overflow inverts `tout_o` and adds one (mod 16) to the PWM phase.
- R8: `pwm_o` is high exactly while the phase is below the width field, control bits [9:6]. A width of 0 keeps it low.
- R9: An overflow sets the flag on `irq_o` when address 2 bit 0 is 1, and does nothing to the flag when that bit is 0. The flag then stays set until a write to address 3 with bit 0 equal to 1. A write of 0 to that bit has no effect.
- R10: With source A on code 7 and source B on code 6, the count changes on the third rising clock edge after `ext_a` rises.
- R11: After reset the count, the reload value, the control register, the enable, `tout_o`, `pwm_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_lvl | input | 8 | Prescaled rate square waves |
| tb1_lvl | input | 1 | Timebase-1 level, selectable for source B |
| ext_a | input | 1 | Asynchronous external input for source A |
| ext_b | input | 1 | Asynchronous external input for source B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 control, 2 enable, 3 flag clear |
| wr_data | input | BUS_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | BUS_W | Combinational read data |
| tout_o | output | 1 | Toggles on every overflow |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
A rate-level edge that completes the AND is seen on the count, `tout_o`, `pwm_o` and `irq_o` after one clock edge. An external pin is seen after three edges. A register write takes effect at the edge that captures it. The bench drives inputs on falling edges. After each stimulus it waits whole cycles before it samples the outputs. The external-pin case is sampled at each of the three edges, so an off-by-one in the synchronizer depth shows up as an early or late change.

// File: rtl/dstmr_pkg.sv
package dstmr_pkg;

    localparam int CTRL_W  = 10;
    localparam int PWM_W   = 4;
    localparam int N_RATES = 8;

    typedef enum logic [2:0] {
        SA_OFF0 = 3'd0, SA_OFF1 = 3'd1, SA_R0 = 3'd2, SA_R1 = 3'd3,
        SA_R2   = 3'd4, SA_ONE  = 3'd5, SA_OFF6 = 3'd6, SA_EXT = 3'd7
    } srca_e;

    typedef enum logic [2:0] {
        SB_R3 = 3'd0, SB_R4 = 3'd1, SB_R5 = 3'd2, SB_TB1 = 3'd3,
        SB_R6 = 3'd4, SB_R7 = 3'd5, SB_ONE = 3'd6, SB_EXT = 3'd7
    } srcb_e;

    typedef struct packed {
        logic [PWM_W-1:0] width;
        srcb_e            src_b;
        srca_e            src_a;
    } ctrl_t;

endpackage

// File: rtl/dstmr_src_sel.sv
module dstmr_src_sel
    import dstmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  srca_e              src_a,
    input  srcb_e              src_b,
    input  logic [N_RATES-1:0] rate_lvl,
    input  logic               tb1_lvl,
    input  logic               ext_a,
    input  logic               ext_b,
    output logic               tick
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync_a;
        logic [SYNC_STAGES-1:0] sync_b;
        logic                   and_prev;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic    lvl_a, lvl_b, gate;

    always_comb begin
        st_d        = st_q;
        st_d.sync_a = {st_q.sync_a[SYNC_STAGES-2:0], ext_a};
        st_d.sync_b = {st_q.sync_b[SYNC_STAGES-2:0], ext_b};

        unique case (src_a)
            SA_R0:   lvl_a = rate_lvl[0];
            SA_R1:   lvl_a = rate_lvl[1];
            SA_R2:   lvl_a = rate_lvl[2];
            SA_ONE:  lvl_a = 1'b1;
            SA_EXT:  lvl_a = st_q.sync_a[SYNC_STAGES-1];
            default: lvl_a = 1'b0;
        endcase

        unique case (src_b)
            SB_R3:   lvl_b = rate_lvl[3];
            SB_R4:   lvl_b = rate_lvl[4];
            SB_R5:   lvl_b = rate_lvl[5];
            SB_TB1:  lvl_b = tb1_lvl;
            SB_R6:   lvl_b = rate_lvl[6];
            SB_R7:   lvl_b = rate_lvl[7];
            SB_ONE:  lvl_b = 1'b1;
            default: lvl_b = st_q.sync_b[SYNC_STAGES-1];
        endcase

        gate          = lvl_a & lvl_b;
        st_d.and_prev = gate;
        tick          = gate & ~st_q.and_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

endmodule

// File: rtl/dstmr_count.sv
module dstmr_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         ovf
);

    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = tick && (st_q.cnt == TOP);
        if (load_we) st_d.rld = load_val;
        if (tick)    st_d.cnt = ovf ? st_q.rld : st_q.cnt + 1'b1;
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != TOP) |=> count == $past(count) + 1'b1); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R4
    AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == TOP) |=> count == $past(st_q.rld)); // R5

endmodule

// File: rtl/dstmr_pwm.sv
module dstmr_pwm
    import dstmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovf,
    input  logic [PWM_W-1:0] width,
    output logic             tout,
    output logic             pwm
);

    typedef struct packed {
        logic [PWM_W-1:0] phase;
        logic             tgl;
    } pwm_st_t;

    pwm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovf) begin
            st_d.phase = st_q.phase + 1'b1;
            st_d.tgl   = ~st_q.tgl;
        end
        tout = st_q.tgl;
        pwm  = st_q.phase < width;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TOUT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> tout != $past(tout)); // R7
    AST_TOUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(tout)); // R7
    AST_PHASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(st_q.phase)); // R7

endmodule

// File: rtl/dual_src_timer.sv
module dual_src_timer
    import dstmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BUS_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RATES-1:0] rate_lvl,
    input  logic               tb1_lvl,
    input  logic               ext_a,
    input  logic               ext_b,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [1:0]         rd_addr,
    output logic [BUS_W-1:0]   rd_data,
    output logic               tout_o,
    output logic               pwm_o,
    output logic               irq_o
);

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_IEN  = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;

    typedef struct packed {
        ctrl_t ctrl;
        logic  ien;
        logic  flag;
    } reg_st_t;

    reg_st_t          st_d, st_q;
    logic             tick, ovf, clr_req;
    logic [CNT_W-1:0] count;

    dstmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_a    (st_q.ctrl.src_a),
        .src_b    (st_q.ctrl.src_b),
        .rate_lvl (rate_lvl),
        .tb1_lvl  (tb1_lvl),
        .ext_a    (ext_a),
        .ext_b    (ext_b),
        .tick     (tick)
    );

    dstmr_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_we  (wr_en && wr_addr == A_DATA),
        .load_val (wr_data[CNT_W-1:0]),
        .count    (count),
        .ovf      (ovf)
    );

    dstmr_pwm u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (ovf),
        .width (st_q.ctrl.width),
        .tout  (tout_o),
        .pwm   (pwm_o)
    );

    always_comb begin
        st_d    = st_q;
        clr_req = wr_en && wr_addr == A_FLAG && wr_data[0];
        if (wr_en && wr_addr == A_CTRL) st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        if (wr_en && wr_addr == A_IEN)  st_d.ien  = wr_data[0];
        if (clr_req)                    st_d.flag = 1'b0;
        if (ovf && st_q.ien)            st_d.flag = 1'b1;

        rd_data = '0;
        unique case (rd_addr)
            A_DATA:  rd_data[CNT_W-1:0]  = count;
            A_CTRL:  rd_data[CTRL_W-1:0] = st_q.ctrl;
            A_IEN:   rd_data[0]          = st_q.ien;
            default: rd_data[0]          = st_q.flag;
        endcase
        irq_o = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && st_q.ien) |=> irq_o); // R9
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_req) |=> irq_o); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !(ovf && st_q.ien)) |=> !irq_o); // R9

endmodule

// File: tb/sim_dual_src_timer.sv
module sim_dual_src_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  rate;
    logic        tb1, exa, exb;
    logic        wr_en;
    logic [1:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic        tout, pwm, irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [CW-1:0] m_cnt, m_rld;
    logic [3:0]    m_ph, m_w;
    logic          m_tout, m_flag, m_ien;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_src_timer #(.CNT_W(CW), .BUS_W(16), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .rate_lvl(rate), .tb1_lvl(tb1),
        .ext_a(exa), .ext_b(exb), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tout_o(tout), .pwm_o(pwm), .irq_o(irq)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic exp_pwm;
        exp_pwm = m_ph < m_w;
        check(rd_data == {8'h00, m_cnt}, {tag, " count"}, rd_data, m_cnt);
        check(tout == m_tout, {tag, " tout"}, tout, m_tout);
        check(pwm == exp_pwm, {tag, " pwm"}, pwm, exp_pwm);
        check(irq == m_flag, {tag, " irq"}, irq, m_flag);
    endtask

    task automatic model_tick();
        if (m_cnt == '1) begin
            m_cnt  = m_rld;
            m_ph   = m_ph + 4'd1;
            m_tout = ~m_tout;
            if (m_ien) m_flag = 1'b1;
        end else begin
            m_cnt = m_cnt + 1'b1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] ctl(input int w, input int b, input int a);
        return {6'd0, 4'(w), 3'(b), 3'(a)};
    endfunction

    task automatic drive(input int line, input logic v);
        if (line < 8)       rate[line] = v;
        else if (line == 8) tb1 = v;
        else if (line == 9) exa = v;
        else                exb = v;
    endtask

    function automatic logic a_hit(input int code, input int line);
        case (code)
            2: return line == 0;
            3: return line == 1;
            4: return line == 2;
            7: return line == 9;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic b_hit(input int code, input int line);
        case (code)
            0: return line == 3;
            1: return line == 4;
            2: return line == 5;
            3: return line == 8;
            4: return line == 6;
            5: return line == 7;
            7: return line == 10;
            default: return 1'b0;
        endcase
    endfunction

    task automatic pulse(input int line, input logic hit, input string tag);
        int hold;
        hold = (line >= 9) ? 4 : 2;
        @(negedge clk);
        drive(line, 1'b1);
        repeat (hold) @(negedge clk);
        drive(line, 1'b0);
        repeat (hold) @(negedge clk);
        if (hit) model_tick();
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rate = '0; tb1 = 0; exa = 0; exb = 0;
        wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_cnt = '0; m_rld = '0; m_ph = '0; m_w = '0;
        m_tout = 0; m_flag = 0; m_ien = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 reset");
        rd_addr = 2'd1; #1;
        check(rd_data == 16'd0, "R11 ctrl", rd_data, 0);
        rd_addr = 2'd0;

        // R2 sweep: source B held constant high
        for (int a = 0; a < 8; a++) begin
            if (a == 5) continue;
            wr(2'd1, ctl(0, 6, a));
            for (int ln = 0; ln < 11; ln++) pulse(ln, a_hit(a, ln), "R2");
        end

        // R3 sweep: source A held constant high
        for (int b = 0; b < 8; b++) begin
            if (b == 6) continue;
            wr(2'd1, ctl(0, b, 5));
            for (int ln = 0; ln < 11; ln++) pulse(ln, b_hit(b, ln), "R3");
        end

        // R1: both constant gives one tick, then no more
        wr(2'd1, ctl(0, 0, 5));
        wr(2'd1, ctl(0, 6, 5));
        @(negedge clk);
        model_tick();
        check_all("R1 const");
        repeat (4) @(negedge clk);
        check_all("R1 const hold");

        // R1: AND gating, A on rate0, B on rate3
        wr(2'd1, ctl(0, 0, 2));
        pulse(0, 1'b0, "R1 gated");
        @(negedge clk); rate[3] = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 B alone");
        pulse(0, 1'b1, "R1 A edge");
        @(negedge clk); rate[3] = 1'b0; rate[0] = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 drop B");
        pulse(3, 1'b1, "R1 B edge");
        @(negedge clk); rate[0] = 1'b0;

        // R10: synchronizer latency
        wr(2'd1, ctl(0, 6, 7));
        @(negedge clk); exa = 1'b1;
        @(negedge clk); check_all("R10 edge1");
        @(negedge clk); check_all("R10 edge2");
        @(negedge clk); model_tick(); check_all("R10 edge3");
        exa = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R10 idle");

        // R6: reload write leaves count alone, readbacks
        wr(2'd0, 16'h00FF); m_rld = 8'hFF;
        check_all("R6 reload write");
        wr(2'd1, ctl(0, 1, 5));
        rd_addr = 2'd1; #1;
        check(rd_data == ctl(0, 1, 5), "R6 ctrl read", rd_data, ctl(0, 1, 5));
        rd_addr = 2'd2; #1;
        check(rd_data == 16'd0, "R6 ien read", rd_data, 0);
        rd_addr = 2'd0;

        // R4 / R5: run to the top, overflow with interrupt disabled
        while (m_cnt != 8'hFF) pulse(4, 1'b1, "R4");
        pulse(4, 1'b1, "R5 R9 wrap no irq");

        // R8 / R7: every tick now overflows
        wr(2'd2, 16'd1); m_ien = 1'b1;
        for (int w = 0; w < 16; w++) begin
            wr(2'd1, ctl(w, 1, 5)); m_w = 4'(w);
            for (int k = 0; k < 16; k++) pulse(4, 1'b1, "R8 R7");
        end

        // R9: write-one-to-clear
        wr(2'd3, 16'd0);
        check_all("R9 write0");
        rd_addr = 2'd3; #1;
        check(rd_data == 16'd1, "R9 flag read", rd_data, 1);
        rd_addr = 2'd0;
        wr(2'd3, 16'd1); m_flag = 1'b0;
        check_all("R9 clear");

        // R5: distinct reload value
        wr(2'd0, 16'h00F0); m_rld = 8'hF0;
        pulse(4, 1'b1, "R5 reload");
        pulse(4, 1'b1, "R4 after reload");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule